// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches a result bus in which every bit travels on a pair of wires, a true rail and a false rail. A pair with neither wire high is the spacer (NULL). A pair with exactly one wire high carries a value (DATA). Each bit is reduced to an acknowledge that is high only while the bit is NULL. The acknowledges are then merged by a tree of two-input Muller C-element stages. Each stage moves to a new level only when both of its inputs agree on that level, and keeps its old level while they disagree.

The root of the tree drives the handshake request back to the producer. While the request is high, the whole bus has been seen as spacer and the producer may launch the next DATA wave. While it is low, the whole bus has been seen as DATA, and the producer must bring every bit back to NULL. A pair with both wires high is an illegal code. It counts as neither DATA nor NULL, and it sets a sticky error flag. The block is modelled with clocked state-holding stages, so it can be synthesized and checked on a clock. Each tree level adds one cycle of latency.

Top module: `dr_completion_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `req_data` is 1 and `code_err` is 0.
- R2: Each bit is decoded from {`rail_t[i]`,`rail_f[i]`]: 00 is NULL, 10 is DATA one, 01 is DATA zero, 11 is illegal. The two DATA codes act identically on the request.
- R3: When every bit holds a DATA code and the bus stays unchanged, `req_data` falls to 0 after exactly DEPTH rising edges, where DEPTH = ceil(log2(WIDTH)) and is at least 1. After DEPTH-1 edges it is still 1.
- R4: When every bit holds NULL and the bus stays unchanged, `req_data` rises to 1 after exactly DEPTH rising edges.
- R5: The bus may move monotonically away from a uniform state, toward DATA from NULL or toward NULL from DATA. While the bus then holds a mix of DATA and NULL bits, `req_data` keeps its previous level, for any width including one that is not a power of two.
- R6: A bit with an illegal code counts as neither DATA nor NULL. It holds `req_data` at its current level even when all other bits agree. `code_err` goes to 1 on the rising edge after the illegal code is present.
- R7: Once set, `code_err` stays 1 until reset, whatever the bus does afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the state-holding stages |
| rst_n | input | 1 | Active-low synchronous reset to the all-NULL-complete state |
| rail_t | input | WIDTH | True rail of each bus bit |
| rail_f | input | WIDTH | False rail of each bus bit |
| req_data | output | 1 | 1: ask for the next DATA wave; 0: ask for the return to NULL |
| code_err | output | 1 | Sticky flag: an illegal rail code has been seen |

## Verification
A stage register that has flipped wrongly, or a pad leaf that is mis-wired, changes what the bus does to the request. A mixed bus then flips the request early, or a fully DATA or fully NULL bus leaves it stuck. Either fault reaches `req_data` within DEPTH edges of the bus pattern that exposes it. The sweep walks every DATA/NULL mix in both phases, so a fault in any subtree shows up as a wrong level on the pin. A wrong illegal-code path shows up one edge later on `code_err`, or as a request that moves while a bad pair is present.

// File: rtl/dr_pkg.sv
package dr_pkg;

  // Rail pair encoding, written as {true, false}
  typedef enum logic [1:0] {
    RAIL_NULL = 2'b00,
    RAIL_ZERO = 2'b01,
    RAIL_ONE  = 2'b10,
    RAIL_BAD  = 2'b11
  } rail_code_e;

  // Spacer acknowledge: high only when neither rail is driven
  function automatic logic null_ack(input logic t, input logic f);
    return ~(t | f);
  endfunction

  // Illegal code detection: both rails driven at once
  function automatic logic bad_code(input logic t, input logic f);
    return t & f;
  endfunction

  // Number of registered merge levels for a given bus width
  function automatic int unsigned tree_depth(input int unsigned w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction

endpackage

// File: rtl/dr_rail_decode.sv
module dr_rail_decode #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic [WIDTH-1:0] ack_null,
  output logic [WIDTH-1:0] bad_bit
);
  import dr_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign ack_null[i] = null_ack(rail_t[i], rail_f[i]);
    assign bad_bit[i]  = bad_code(rail_t[i], rail_f[i]);
  end

endmodule

// File: rtl/dr_celem.sv
module dr_celem (
  input  logic clk,
  input  logic rst_n,
  input  logic in_a,
  input  logic in_b,
  output logic out_q
);

  logic agree;
  assign agree = (in_a == in_b);

  always_ff @(posedge clk) begin
    if (!rst_n)
      out_q <= 1'b1;
    else if (agree)
      out_q <= in_a;
  end

endmodule

// File: rtl/dr_celem_tree.sv
module dr_celem_tree #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] leaf_in,
  output logic             root_q,
  output logic             root_l,
  output logic             root_r
);
  import dr_pkg::*;

  localparam int DEPTH  = tree_depth(WIDTH);
  localparam int LEAVES = 1 << DEPTH;

  logic [LEAVES-1:0] lf;
  logic [LEAVES-1:1] node_q;
  logic [LEAVES-1:1] child_a;
  logic [LEAVES-1:1] child_b;

  // Padding leaves copy leaf 0 so they never block agreement
  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < WIDTH) begin : g_real
      assign lf[k] = leaf_in[k];
    end else begin : g_pad
      assign lf[k] = leaf_in[0];
    end
  end

  // Heap-ordered nodes: node i merges children 2i and 2i+1
  for (genvar i = 1; i < LEAVES; i++) begin : g_node
    if (2 * i >= LEAVES) begin : g_from_leaf
      assign child_a[i] = lf[2 * i - LEAVES];
      assign child_b[i] = lf[2 * i + 1 - LEAVES];
    end else begin : g_from_node
      assign child_a[i] = node_q[2 * i];
      assign child_b[i] = node_q[2 * i + 1];
    end
    dr_celem u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .in_a  (child_a[i]),
      .in_b  (child_b[i]),
      .out_q (node_q[i])
    );
  end

  assign root_q = node_q[1];
  assign root_l = child_a[1];
  assign root_r = child_b[1];

endmodule

// File: rtl/dr_completion_ctrl.sv
module dr_completion_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic             req_data,
  output logic             code_err
);

  logic [WIDTH-1:0] ack_null;
  logic [WIDTH-1:0] bad_bit;
  logic [WIDTH-1:0] leaf;
  logic             root_q;
  logic             root_l;
  logic             root_r;
  logic             err_q;

  dr_rail_decode #(.WIDTH(WIDTH)) u_decode (
    .rail_t   (rail_t),
    .rail_f   (rail_f),
    .ack_null (ack_null),
    .bad_bit  (bad_bit)
  );

  // An illegal bit mirrors the current request level: it sides with neither phase
  for (genvar i = 0; i < WIDTH; i++) begin : g_leaf_sel
    assign leaf[i] = bad_bit[i] ? root_q : ack_null[i];
  end

  dr_celem_tree #(.WIDTH(WIDTH)) u_tree (
    .clk     (clk),
    .rst_n   (rst_n),
    .leaf_in (leaf),
    .root_q  (root_q),
    .root_l  (root_l),
    .root_r  (root_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      err_q <= 1'b0;
    else if (|bad_bit)
      err_q <= 1'b1;
  end

  assign req_data = root_q;
  assign code_err = err_q;

endmodule

// File: rtl/dr_completion_chk.sv
module dr_completion_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_data,
  input logic             code_err,
  input logic [WIDTH-1:0] bad_bit,
  input logic             root_l,
  input logic             root_r
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_data && !code_err));

  // R3 and R4: the root takes the level its two subtrees agree on
  assert_root_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (root_l == root_r) |=> (req_data == $past(root_l)));

  assert_mixed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (root_l != root_r) |=> $stable(req_data));

  assert_bad_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bad_bit) |=> code_err);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> code_err);

endmodule

bind dr_completion_ctrl dr_completion_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_data (req_data),
  .code_err (code_err),
  .bad_bit  (bad_bit),
  .root_l   (root_l),
  .root_r   (root_r)
);

// File: tb/dr_completion_ctrl_tb.sv
module dr_completion_ctrl_tb;
  localparam int W   = 5;
  localparam int TD  = $clog2(W);
  localparam logic [W-1:0] ALL = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] rail_t = '0;
  logic [W-1:0] rail_f = '0;
  logic         req_data;
  logic         code_err;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  dr_completion_ctrl #(.WIDTH(W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .rail_t   (rail_t),
    .rail_f   (rail_f),
    .req_data (req_data),
    .code_err (code_err)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // dmask: bits carrying DATA, val: their values, bmask: bits with illegal code
  task automatic drive(input logic [W-1:0] dmask, input logic [W-1:0] val,
                       input logic [W-1:0] bmask);
    @(negedge clk);
    rail_t = (dmask & val) | bmask;
    rail_f = (dmask & ~val) | bmask;
  endtask

  task automatic settle();
    repeat (TD + 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rail_t = '0;
    rail_f = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 req after reset", req_data, 1'b1);
    check("R1 err after reset", code_err, 1'b0);

    // R3 exact latency to DATA completion
    drive(ALL, 5'b10110, '0);
    repeat (TD - 1) @(posedge clk);
    @(negedge clk);
    check("R3 before latency", req_data, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R3 at latency", req_data, 1'b0);

    // R4 exact latency to NULL completion
    drive('0, '0, '0);
    repeat (TD - 1) @(posedge clk);
    @(negedge clk);
    check("R4 before latency", req_data, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R4 at latency", req_data, 1'b1);

    // R2 R3 R4 R5: every DATA/NULL mix in both phases
    for (int m = 0; m < (1 << W); m++) begin
      logic [W-1:0] msk;
      logic [W-1:0] v;
      msk = m[W-1:0];
      v   = msk ^ 5'b01011 ^ W'(m >> 1);
      drive('0, '0, '0);
      settle();
      drive(msk, v, '0);
      settle();
      check((msk == ALL) ? "R3 all data" : "R5 mix from null",
            req_data, (msk == ALL) ? 1'b0 : 1'b1);
      drive(ALL, ~v, '0);
      settle();
      check("R2 R3 data phase", req_data, 1'b0);
      drive(msk, ~v, '0);
      settle();
      check((msk == '0) ? "R4 all null" : "R5 mix from data",
            req_data, (msk == '0) ? 1'b1 : 1'b0);
      drive('0, '0, '0);
      settle();
    end
    check("R1 err clean after sweep", code_err, 1'b0);

    // R6 R7: one illegal bit at each position
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] bm;
      bm = W'(1) << k;
      do_reset();
      drive(ALL & ~bm, 5'b11001, bm);
      settle();
      check("R6 bad bit blocks data", req_data, 1'b1);
      check("R6 err set", code_err, 1'b1);
      drive(ALL, 5'b11001, '0);
      settle();
      check("R6 completes once fixed", req_data, 1'b0);
      drive('0, '0, bm);
      settle();
      check("R6 bad bit blocks null", req_data, 1'b0);
      drive('0, '0, '0);
      settle();
      check("R4 null after bad", req_data, 1'b1);
      check("R7 err sticky", code_err, 1'b1);
    end

    do_reset();
    check("R1 err cleared by reset", code_err, 1'b0);
    check("R1 req after second reset", req_data, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule